// File: doc/BRIEF.md
# Slot-Based Interrupt Router

This block turns interrupt pin activity from add-in devices into a single processor interrupt. Each event names the slot that raised it and which of its four interrupt pins (A to D, index 0 to 3) was involved. A fixed slot table converts the slot and pin pair to an internal interrupt number. Two 32-bit configuration words then decide what the processor line does for that number. One word selects pulse or level behaviour per line. The other gives the level to drive.

Internal numbers begin at 32. The configuration bit for an event is its internal number minus 32, which is the same as its line index. Slots outside the table keep the raw pin number as their internal number. That number falls below 32, so it has no configuration bit and the event is dropped. The output is registered. The pin level that caused an event plays no part: in level mode the driven value comes only from the polarity word. The configuration words are plain inputs, and nothing in the block writes them.

Top module: `irq_slot_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `irq_out` is low.
- R2: An event from slot 5 with pin index n selects line n (n = 0..3).
- R3: An event from slot 6 selects line 4 and an event from slot 7 selects line 5, whatever the pin index.
- R4: An event from slots 8 to 12 with pin index n selects line (slot − 8 + n + 6), covering lines 6 to 13.
- R5: An event from any slot outside 5 to 12 leaves `irq_out` unchanged, whatever the configuration words hold.
- R6: When bit L of `edge_cfg` is set, an event on line L drives `irq_out` high in the cycle after the strobe edge, for exactly one cycle, after which it is low.
- R7: When bit L of `edge_cfg` is clear, an event on line L sets `irq_out` to bit L of `pol_cfg` from the next cycle on, and it holds that value until the next accepted event.
- R8: Without `ev_valid` high, changes to slot, pin or either configuration word do not change `irq_out`.
- R9: Edge events on consecutive cycles keep `irq_out` high for one cycle per event. A level event in the cycle after a pulse replaces the pulse's trailing low with its polarity value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Strobe: slot and pin describe an interrupt event this cycle |
| ev_slot | input | 5 | Slot number of the device raising the event |
| ev_pin | input | 2 | Interrupt pin index (0 = A .. 3 = D) |
| edge_cfg | input | 32 | Per-line select: 1 = pulse output, 0 = level output |
| pol_cfg | input | 32 | Per-line level driven in level mode |
| irq_out | output | 1 | Registered processor interrupt line |

## Verification
The bench sweeps every mapped slot and pin pair twice. First only the expected line's polarity bit is set; then every bit except that one is set. The output must read 1 and then 0, so an event that lands on any other line gives a wrong value. Unmapped slots at both ends of the table are sent after the output has been driven high, with edge and polarity words chosen so that any line they reach would change it. Pulse tests start from both a low and a high output, and a back-to-back test separates a single pulse, merged pulses and a level event that overrides a pulse. A final test changes inputs without the strobe to show that the output holds.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Register image of the output driver
    typedef struct packed {
        logic irq;      // value presented on the processor line
        logic pulsing;  // current high level is a one-cycle pulse
    } drv_state_t;

endpackage

// File: rtl/slot_line_map.sv
// Converts a slot/pin pair into an internal interrupt number.
module slot_line_map #(
    parameter int SLOT_W      = 5,
    parameter int PIN_W       = 2,
    parameter int NUM_W       = 7,
    parameter int IRQ_BASE    = 32,
    parameter int SLOT_MULTI  = 5,   // onboard device using all four pins
    parameter int SLOT_SOLO_A = 6,
    parameter int SLOT_SOLO_B = 7,
    parameter int LINE_SOLO_A = 4,
    parameter int LINE_SOLO_B = 5,
    parameter int EXP_FIRST   = 8,
    parameter int EXP_LAST    = 12,
    parameter int EXP_LINE0   = 6
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIN_W-1:0]  pin,
    output logic [NUM_W-1:0]  irq_num
);
    localparam int WRAP_W = 2;  // pins wrap modulo four on the multi-pin slot

    logic [NUM_W-1:0] exp_num;

    // rotated pin swizzle for expansion slots
    assign exp_num = NUM_W'(slot) - NUM_W'(EXP_FIRST) + NUM_W'(pin)
                   + NUM_W'(EXP_LINE0 + IRQ_BASE);

    always_comb begin
        irq_num = NUM_W'(pin);  // untranslated by default
        if (slot == SLOT_W'(SLOT_MULTI)) begin
            irq_num = NUM_W'(pin[WRAP_W-1:0]) + NUM_W'(IRQ_BASE);
        end else if (slot == SLOT_W'(SLOT_SOLO_A)) begin
            irq_num = NUM_W'(LINE_SOLO_A + IRQ_BASE);
        end else if (slot == SLOT_W'(SLOT_SOLO_B)) begin
            irq_num = NUM_W'(LINE_SOLO_B + IRQ_BASE);
        end else if (slot >= SLOT_W'(EXP_FIRST) && slot <= SLOT_W'(EXP_LAST)) begin
            irq_num = exp_num;
        end
    end
endmodule

// File: rtl/line_cfg_sel.sv
// Picks the edge-select and polarity bits for an internal number.
module line_cfg_sel #(
    parameter int NUM_W     = 7,
    parameter int IRQ_BASE  = 32,
    parameter int NUM_LINES = 32
) (
    input  logic [NUM_W-1:0]     irq_num,
    input  logic [NUM_LINES-1:0] edge_cfg,
    input  logic [NUM_LINES-1:0] pol_cfg,
    output logic                 in_window,
    output logic                 edge_bit,
    output logic                 pol_bit
);
    logic [NUM_LINES-1:0] line_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            assign line_hit[g] = (irq_num == NUM_W'(IRQ_BASE + g));
        end
    endgenerate

    assign in_window = |line_hit;
    assign edge_bit  = |(line_hit & edge_cfg);
    assign pol_bit   = |(line_hit & pol_cfg);
endmodule

// File: rtl/irq_drive.sv
// Registered output stage: pulse or polarity-driven level.
module irq_drive
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_hit,
    input  logic edge_bit,
    input  logic pol_bit,
    output logic irq
);
    drv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_hit) begin
            st_d.irq     = edge_bit ? 1'b1 : pol_bit;
            st_d.pulsing = edge_bit;
        end else if (st_q.pulsing) begin
            st_d.irq     = 1'b0;
            st_d.pulsing = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R6
    edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hit && edge_bit) |=> irq);
    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulsing && !ev_hit) |=> !irq);
    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hit && !edge_bit) |=> (irq == $past(pol_bit)));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pulsing && !ev_hit) |=> $stable(irq));
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router #(
    parameter int SLOT_W    = 5,
    parameter int PIN_W     = 2,
    parameter int NUM_LINES = 32,
    parameter int IRQ_BASE  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_valid,
    input  logic [SLOT_W-1:0]    ev_slot,
    input  logic [PIN_W-1:0]     ev_pin,
    input  logic [NUM_LINES-1:0] edge_cfg,
    input  logic [NUM_LINES-1:0] pol_cfg,
    output logic                 irq_out
);
    localparam int NUM_W = $clog2(IRQ_BASE + NUM_LINES) + 1;

    logic [NUM_W-1:0] map_num;
    logic             in_window, edge_bit, pol_bit, ev_hit;

    slot_line_map #(
        .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE)
    ) i_map (
        .slot(ev_slot), .pin(ev_pin), .irq_num(map_num)
    );

    line_cfg_sel #(
        .NUM_W(NUM_W), .IRQ_BASE(IRQ_BASE), .NUM_LINES(NUM_LINES)
    ) i_sel (
        .irq_num(map_num), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
        .in_window(in_window), .edge_bit(edge_bit), .pol_bit(pol_bit)
    );

    assign ev_hit = ev_valid && in_window;

    irq_drive i_drive (
        .clk(clk), .rst_n(rst_n), .ev_hit(ev_hit),
        .edge_bit(edge_bit), .pol_bit(pol_bit), .irq(irq_out)
    );

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_out);
    // R3
    solo_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_slot == SLOT_W'(6)) |-> (map_num == NUM_W'(IRQ_BASE + 4)));
    // R5
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_slot < SLOT_W'(5) || ev_slot > SLOT_W'(12)))
        |=> $stable(irq_out));
endmodule

// File: tb/test_irq_slot_router.sv
module test_irq_slot_router;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [4:0]  ev_slot = '0;
    logic [1:0]  ev_pin = '0;
    logic [31:0] edge_cfg = '0;
    logic [31:0] pol_cfg = '0;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_slot_router i_irq_slot_router (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_slot(ev_slot),
        .ev_pin(ev_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
        .irq_out(irq_out)
    );

    // expected line per the slot table; -1 when the slot is not mapped
    function automatic int exp_line(int s, int p);
        if (s == 5) return p;
        if (s == 6) return 4;
        if (s == 7) return 5;
        if (s >= 8 && s <= 12) return s - 8 + p + 6;
        return -1;
    endfunction

    task automatic check(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // one strobed event; returns at the negedge after the capturing posedge
    task automatic send(int s, int p);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_slot  = 5'(s);
        ev_pin   = 2'(p);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic probe(int s, int p, string req);
        int ln = exp_line(s, p);
        edge_cfg = '0;
        pol_cfg  = 32'(1) << ln;
        send(s, p);
        check(irq_out, 1'b1, req, $sformatf("slot %0d pin %0d only own bit", s, p));
        pol_cfg  = ~(32'(1) << ln);
        send(s, p);
        check(irq_out, 1'b0, req, $sformatf("slot %0d pin %0d all but own bit", s, p));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(irq_out, 1'b0, "R1", "during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_out, 1'b0, "R1", "first cycle after reset");
    endtask

    task automatic t_slot5();
        for (int p = 0; p < 4; p++) probe(5, p, "R2");
    endtask

    task automatic t_solo();
        for (int p = 0; p < 4; p++) begin
            probe(6, p, "R3");
            probe(7, p, "R3");
        end
    endtask

    task automatic t_expansion();
        for (int s = 8; s <= 12; s++)
            for (int p = 0; p < 4; p++) probe(s, p, "R4");
    endtask

    task automatic t_unmapped();
        edge_cfg = '0;
        pol_cfg  = '1;
        send(6, 0);
        check(irq_out, 1'b1, "R5", "set high before unmapped events");
        edge_cfg = '1;
        pol_cfg  = '0;
        send(4, 3);
        check(irq_out, 1'b1, "R5", "slot 4 ignored");
        send(0, 0);
        check(irq_out, 1'b1, "R5", "slot 0 ignored");
        send(13, 1);
        check(irq_out, 1'b1, "R5", "slot 13 ignored");
        send(31, 2);
        check(irq_out, 1'b1, "R5", "slot 31 ignored");
        @(negedge clk);
        check(irq_out, 1'b1, "R5", "still high afterwards");
    endtask

    task automatic t_edge();
        // from a high level output
        edge_cfg = 32'(1) << 4;
        pol_cfg  = '0;
        send(6, 2);
        check(irq_out, 1'b1, "R6", "pulse high from high start");
        @(negedge clk);
        check(irq_out, 1'b0, "R6", "pulse ends after one cycle");
        @(negedge clk);
        check(irq_out, 1'b0, "R6", "stays low after pulse");
        // from low, on an expansion line
        edge_cfg = 32'(1) << 13;
        pol_cfg  = '1;
        send(12, 3);
        check(irq_out, 1'b1, "R6", "pulse high on line 13");
        @(negedge clk);
        check(irq_out, 1'b0, "R6", "pulse low despite polarity set");
    endtask

    task automatic t_level_hold();
        edge_cfg = '0;
        pol_cfg  = 32'(1) << 2;
        send(5, 2);
        check(irq_out, 1'b1, "R7", "level high");
        repeat (4) @(negedge clk);
        check(irq_out, 1'b1, "R7", "level held");
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        ev_slot  = 5'd7;
        ev_pin   = 2'd1;
        pol_cfg  = '0;
        edge_cfg = '1;
        repeat (3) @(negedge clk);
        check(irq_out, 1'b1, "R8", "no strobe keeps high");
        edge_cfg = '0;
        send(7, 1);
        check(irq_out, 1'b0, "R8", "strobed event takes effect");
        pol_cfg = '1;
        ev_slot = 5'd9;
        repeat (3) @(negedge clk);
        check(irq_out, 1'b0, "R8", "no strobe keeps low");
    endtask

    task automatic t_back_to_back();
        edge_cfg = 32'(1) << 5;
        pol_cfg  = '0;
        @(negedge clk);
        ev_valid = 1'b1; ev_slot = 5'd7; ev_pin = 2'd0;
        @(negedge clk);
        check(irq_out, 1'b1, "R9", "first pulse");
        @(negedge clk);
        ev_valid = 1'b0;
        check(irq_out, 1'b1, "R9", "second pulse merged");
        @(negedge clk);
        check(irq_out, 1'b0, "R9", "low after two pulses");
        // pulse followed at once by a level event
        pol_cfg = 32'(1) << 4;
        @(negedge clk);
        ev_valid = 1'b1; ev_slot = 5'd7;
        @(negedge clk);
        ev_slot = 5'd6;
        check(irq_out, 1'b1, "R9", "pulse before level event");
        @(negedge clk);
        ev_valid = 1'b0;
        check(irq_out, 1'b1, "R9", "level event replaces trailing low");
        @(negedge clk);
        check(irq_out, 1'b1, "R9", "level held after pulse");
    endtask

    initial begin
        t_reset();
        t_slot5();
        t_solo();
        t_expansion();
        t_unmapped();
        t_edge();
        t_level_hold();
        t_no_strobe();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule